// File: doc/BRIEF.md
# Wake-Source Pad Configuration Register

This block is a single 32-bit memory-mapped configuration word in the system clock domain. Software uses it to arm the external reset pin and a small set of GPIO pins as wake sources for a hibernate controller. A write takes effect on the next clock edge. No write-complete handshake is needed before the next access.

Two writable bits are held in the word: an unlock bit and a reset-pin wake enable. The GPIO wake enable and level vectors come in from outside the block. While the word is unlocked, the effective configuration is the reset enable plus both GPIO vectors. While it is locked, the effective configuration is all zeros.

The block keeps a latched copy of the last configuration it sent to the pad ring. Whenever the effective configuration differs from that copy, it launches a transfer. The transfer request stays high until the pad ring acknowledges it. A read-only completion bit reports whether the pads hold the current configuration. A hibernate request that arrives while the word is still unlocked raises an error pulse. A hibernate-exit reset returns the whole block to its reset state.

Top module: `wake_cfg_top`

## Requirements
- R1: After reset, a read of the register returns 0x80000000, and all pad outputs and the transfer request are 0.
- R2: A transfer launched while the unlock bit (bit 0) is 0 drives zero on the reset-wake and both GPIO pad outputs, whatever the stored bit 4 and the GPIO inputs hold.
- R3: Bit 4 (reset-pin wake enable) is stored and read back regardless of bit 0. It reaches the reset-wake pad output only through a transfer launched while bit 0 is 1.
- R4: Bit 31 reads 0 from the first cycle in which the effective configuration differs from the configuration last sent to the pads. It reads 1 again in the cycle after the pad acknowledge ends the final outstanding transfer.
- R5: Bits 30..5 and 3..1 always read 0, and writing 1 to them has no effect on any output.
- R6: A write to the register address is visible in a read in the next cycle. A read of any other address returns 0, and a write to any other address is ignored.
- R7: The transfer request rises one cycle after a configuration difference is seen while idle, and it stays high with the pad outputs stable until acknowledged. A change made during a transfer causes exactly one further transfer carrying the newest values.
- R8: A hibernate request sampled while bit 0 is 1 makes the error output 1 for exactly the next cycle. A hibernate request with bit 0 at 0 does not raise it.
- R9: A hibernate-exit reset returns the register to 0x80000000 and clears the pad outputs, the transfer request and the error output.
- R10: A pad acknowledge that arrives while no transfer is outstanding is ignored.
- R11: While bit 0 is 1, a change on the GPIO wake enable or level inputs starts a transfer. While bit 0 is 0, such changes start none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hibExitRst | input | 1 | Synchronous reset issued on exit from hibernate |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read enable |
| regAddr | input | 8 | Register byte address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational, 0 when not selected |
| gpioWakeEn | input | 4 | Per-pin GPIO wake enables |
| gpioWakeLvl | input | 4 | Per-pin GPIO wake levels |
| padAck | input | 1 | Pad ring acknowledge of the outstanding transfer |
| hibReq | input | 1 | Hibernate request |
| padRstWakeEn | output | 1 | Latched reset-pin wake enable sent to pads |
| padGpioWakeEn | output | 4 | Latched GPIO wake enables sent to pads |
| padGpioWakeLvl | output | 4 | Latched GPIO wake levels sent to pads |
| padXferReq | output | 1 | Transfer to the pad ring outstanding |
| hibErr | output | 1 | One-cycle pulse: hibernate requested while unlocked |

## Verification
The hardest condition to reach is a configuration change that lands inside an outstanding transfer, followed by a second change before the acknowledge. The bench holds the pad acknowledge back for several cycles and changes the GPIO inputs twice in that window. It then confirms that exactly one follow-up transfer is launched and that it carries the last values. A second hard-to-reach case is an acknowledge that arrives while no transfer is outstanding. The bench forces that directly on the acknowledge pin and checks that the completion bit and the pads do not move.

// File: rtl/wake_cfg_pkg.sv
package wake_cfg_pkg;
  localparam int DATA_W    = 32;
  localparam int UNLK_BIT  = 0;
  localparam int RSTEN_BIT = 4;
  localparam int DONE_BIT  = 31;

  typedef struct packed {
    logic launch;   // latch effective config into pad copy
    logic done;     // completion status for readback
  } ctlStrobe_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_XFER = 1'b1} xferState_e;
endpackage

// File: rtl/wake_cfg_dp.sv
module wake_cfg_dp
  import wake_cfg_pkg::*;
#(
  parameter int GPIO_N   = 4,
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h2C,
  localparam int CFG_W   = 1 + 2*GPIO_N
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hibExitRst,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [GPIO_N-1:0] gpioWakeEn,
  input  logic [GPIO_N-1:0] gpioWakeLvl,
  input  ctlStrobe_t        strobe,
  output logic [DATA_W-1:0] regRdata,
  output logic [CFG_W-1:0]  padCfg,
  output logic              cfgDiffer,
  output logic              unlockQ
);
  logic rstEnQ;
  logic addrHit;
  logic [CFG_W-1:0] effCfg;

  assign addrHit = (regAddr == CFG_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlockQ <= 1'b0;
      rstEnQ  <= 1'b0;
    end else if (hibExitRst) begin
      unlockQ <= 1'b0;
      rstEnQ  <= 1'b0;
    end else if (regWr && addrHit) begin
      unlockQ <= regWdata[UNLK_BIT];
      rstEnQ  <= regWdata[RSTEN_BIT];
    end
  end

  // Effective configuration: masked to zero while locked
  assign effCfg = unlockQ ? {rstEnQ, gpioWakeEn, gpioWakeLvl} : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              padCfg <= '0;
    else if (hibExitRst)    padCfg <= '0;
    else if (strobe.launch) padCfg <= effCfg;
  end

  assign cfgDiffer = (effCfg != padCfg);

  always_comb begin
    regRdata = '0;
    if (regRd && addrHit) begin
      regRdata[DONE_BIT]  = strobe.done;
      regRdata[RSTEN_BIT] = rstEnQ;
      regRdata[UNLK_BIT]  = unlockQ;
    end
  end
endmodule

// File: rtl/wake_cfg_ctl.sv
module wake_cfg_ctl
  import wake_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hibExitRst,
  input  logic       cfgDiffer,
  input  logic       unlockQ,
  input  logic       padAck,
  input  logic       hibReq,
  output ctlStrobe_t strobe,
  output logic       xferBusy,
  output logic       hibErr
);
  xferState_e state, stateNext;

  always_comb begin
    stateNext     = state;
    strobe.launch = 1'b0;
    unique case (state)
      ST_IDLE: if (cfgDiffer) begin
        strobe.launch = 1'b1;
        stateNext     = ST_XFER;
      end
      ST_XFER: if (padAck) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign xferBusy    = (state == ST_XFER);
  assign strobe.done = !xferBusy && !cfgDiffer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      hibErr <= 1'b0;
    end else if (hibExitRst) begin
      state  <= ST_IDLE;
      hibErr <= 1'b0;
    end else begin
      state  <= stateNext;
      hibErr <= hibReq && unlockQ;
    end
  end
endmodule

// File: rtl/wake_cfg_top.sv
module wake_cfg_top
  import wake_cfg_pkg::*;
#(
  parameter int GPIO_N = 4,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h2C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hibExitRst,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [GPIO_N-1:0] gpioWakeEn,
  input  logic [GPIO_N-1:0] gpioWakeLvl,
  input  logic              padAck,
  input  logic              hibReq,
  output logic              padRstWakeEn,
  output logic [GPIO_N-1:0] padGpioWakeEn,
  output logic [GPIO_N-1:0] padGpioWakeLvl,
  output logic              padXferReq,
  output logic              hibErr
);
  localparam int CFG_W = 1 + 2*GPIO_N;

  ctlStrobe_t       strobe;
  logic             cfgDiffer;
  logic             unlockQ;
  logic [CFG_W-1:0] padCfg;

  wake_cfg_dp #(.GPIO_N(GPIO_N), .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .hibExitRst(hibExitRst),
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr), .regWdata(regWdata),
    .gpioWakeEn(gpioWakeEn), .gpioWakeLvl(gpioWakeLvl),
    .strobe(strobe), .regRdata(regRdata), .padCfg(padCfg),
    .cfgDiffer(cfgDiffer), .unlockQ(unlockQ)
  );

  wake_cfg_ctl u_ctl (
    .clk(clk), .rstN(rstN), .hibExitRst(hibExitRst),
    .cfgDiffer(cfgDiffer), .unlockQ(unlockQ), .padAck(padAck), .hibReq(hibReq),
    .strobe(strobe), .xferBusy(padXferReq), .hibErr(hibErr)
  );

  assign padRstWakeEn   = padCfg[CFG_W-1];
  assign padGpioWakeEn  = padCfg[2*GPIO_N-1:GPIO_N];
  assign padGpioWakeLvl = padCfg[GPIO_N-1:0];
endmodule

// File: rtl/wake_cfg_chk.sv
module wake_cfg_chk #(
  parameter int GPIO_N = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              hibExitRst,
  input logic              unlockQ,
  input logic              padAck,
  input logic              hibReq,
  input logic              padXferReq,
  input logic              hibErr,
  input logic              padRstWakeEn,
  input logic [GPIO_N-1:0] padGpioWakeEn,
  input logic [GPIO_N-1:0] padGpioWakeLvl,
  input logic [31:0]       regRdata
);
  a_r2_locked_pads_zero: assert property (@(posedge clk) disable iff (!rstN || hibExitRst)
    ($rose(padXferReq) && !$past(unlockQ)) |->
      (!padRstWakeEn && padGpioWakeEn == '0 && padGpioWakeLvl == '0));

  a_r7_pads_stable: assert property (@(posedge clk) disable iff (!rstN || hibExitRst)
    (padXferReq && $past(padXferReq)) |->
      ($stable(padRstWakeEn) && $stable(padGpioWakeEn) && $stable(padGpioWakeLvl)));

  a_r4_ack_ends_req: assert property (@(posedge clk) disable iff (!rstN || hibExitRst)
    (padXferReq && padAck) |=> !padXferReq);

  a_r8_err_raised: assert property (@(posedge clk) disable iff (!rstN || hibExitRst)
    (hibReq && unlockQ) |=> hibErr);

  a_r8_err_spurious: assert property (@(posedge clk) disable iff (!rstN || hibExitRst)
    !(hibReq && unlockQ) |=> !hibErr);

  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regRdata[30:5] == '0) && (regRdata[3:1] == '0));
endmodule

bind wake_cfg_top wake_cfg_chk #(.GPIO_N(GPIO_N)) u_chk (
  .clk(clk), .rstN(rstN), .hibExitRst(hibExitRst), .unlockQ(unlockQ),
  .padAck(padAck), .hibReq(hibReq), .padXferReq(padXferReq), .hibErr(hibErr),
  .padRstWakeEn(padRstWakeEn), .padGpioWakeEn(padGpioWakeEn),
  .padGpioWakeLvl(padGpioWakeLvl), .regRdata(regRdata)
);

// File: tb/wake_cfg_top_bench.sv
module wake_cfg_top_bench;
  localparam logic [7:0] A = 8'h2C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hibExitRst = 1'b0;
  logic regWr = 1'b0, regRd = 1'b1;
  logic [7:0] regAddr = A;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [3:0] gpioWakeEn = '0, gpioWakeLvl = '0;
  logic padAck = 1'b0, hibReq = 1'b0;
  logic padRstWakeEn, padXferReq, hibErr;
  logic [3:0] padGpioWakeEn, padGpioWakeLvl;

  int errors = 0, checks = 0;
  int ackLat = 2, ackCnt = 0, rises = 0;
  bit autoAck = 1'b1, prevReq = 1'b0;

  // reference model state
  bit mUnlock, mRstEn, mBusy, mErr;
  logic [8:0] mShadow;

  always #5 clk = ~clk;

  wake_cfg_top u_wake_cfg_top (
    .clk(clk), .rstN(rstN), .hibExitRst(hibExitRst), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .gpioWakeEn(gpioWakeEn), .gpioWakeLvl(gpioWakeLvl), .padAck(padAck), .hibReq(hibReq),
    .padRstWakeEn(padRstWakeEn), .padGpioWakeEn(padGpioWakeEn),
    .padGpioWakeLvl(padGpioWakeLvl), .padXferReq(padXferReq), .hibErr(hibErr)
  );

  function automatic logic [8:0] effNow();
    return mUnlock ? {mRstEn, gpioWakeEn, gpioWakeLvl} : 9'h0;
  endfunction

  function automatic logic [31:0] expRead();
    logic [31:0] v = '0;
    if (regRd && regAddr == A) begin
      v[31] = !mBusy && (effNow() == mShadow);
      v[4]  = mRstEn;
      v[0]  = mUnlock;
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rstN || hibExitRst) begin
      mUnlock = 0; mRstEn = 0; mBusy = 0; mErr = 0; mShadow = '0;
    end else begin
      bit errN;
      errN = hibReq && mUnlock;
      if (mBusy) begin
        if (padAck) mBusy = 0;
      end else if (effNow() != mShadow) begin
        mShadow = effNow();
        mBusy = 1;
      end
      if (regWr && regAddr == A) begin
        mUnlock = regWdata[0];
        mRstEn  = regWdata[4];
      end
      mErr = errN;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("R2 pads", {23'h0, padRstWakeEn, padGpioWakeEn, padGpioWakeLvl}, {23'h0, mShadow});
    chk("R7 xfer req", {31'h0, padXferReq}, {31'h0, mBusy});
    chk("R8 hibErr", {31'h0, hibErr}, {31'h0, mErr});
    chk("R4 readback", regRdata, expRead());
  endtask

  task automatic cyc();
    @(negedge clk);
    compareAll();
    if (padXferReq && !prevReq) rises++;
    prevReq = padXferReq;
    if (autoAck) begin
      if (padXferReq) begin
        padAck = (ackCnt >= ackLat);
        ackCnt++;
      end else begin
        padAck = 1'b0;
        ackCnt = 0;
      end
    end
  endtask

  task automatic cycN(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(logic [31:0] d);
    regWr = 1'b1; regWdata = d;
    cyc();
    regWr = 1'b0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cycN(3);
    rstN = 1'b1;
    cyc();
    chk("R1 reset read", regRdata, 32'h8000_0000);
    chk("R1 reset pads", {22'h0, padXferReq, padRstWakeEn, padGpioWakeEn, padGpioWakeLvl}, 32'h0);

    // R5/R6: all-ones write, reserved ignored, visible next cycle, R4 done drops
    gpioWakeEn = 4'hA; gpioWakeLvl = 4'h5;
    wr(32'hFFFF_FFFF);
    chk("R6 R5 write visible", regRdata, 32'h0000_0011);
    cyc();
    chk("R7 req rises one cycle after diff", {31'h0, padXferReq}, 32'h1);
    cycN(8);
    chk("R4 done after ack", regRdata, 32'h8000_0011);
    chk("R3 rst pad when unlocked", {31'h0, padRstWakeEn}, 32'h1);
    chk("R11 gpio pads", {24'h0, padGpioWakeEn, padGpioWakeLvl}, 32'hA5);

    // R7: two changes inside a long transfer -> exactly one more transfer
    ackLat = 6; rises = 0;
    gpioWakeLvl = 4'h3;
    cycN(3);
    gpioWakeEn = 4'h1;
    cyc();
    gpioWakeLvl = 4'hC;
    cycN(25);
    chk("R7 one follow-up transfer", rises, 2);
    chk("R7 newest values", {24'h0, padGpioWakeEn, padGpioWakeLvl}, 32'h1C);
    ackLat = 1;

    // R6: other address ignored and reads zero
    regAddr = 8'h30;
    cyc();
    chk("R6 other addr read", regRdata, 32'h0);
    wr(32'h0);
    regAddr = A;
    cyc();
    chk("R6 other addr write ignored", regRdata, 32'h8000_0011);

    // R8: hibernate request while unlocked
    hibReq = 1'b1;
    cyc();
    hibReq = 1'b0;
    chk("R8 err raised", {31'h0, hibErr}, 32'h1);
    cyc();
    chk("R8 err one cycle", {31'h0, hibErr}, 32'h0);

    // R2/R3: lock with rst enable kept
    wr(32'h0000_0010);
    cycN(8);
    chk("R3 rst stored while locked", regRdata, 32'h8000_0010);
    chk("R2 pads zero locked", {23'h0, padRstWakeEn, padGpioWakeEn, padGpioWakeLvl}, 32'h0);

    // R11: gpio changes while locked start nothing
    rises = 0;
    gpioWakeEn = 4'hF; gpioWakeLvl = 4'h9;
    cycN(6);
    chk("R11 no transfer when locked", rises, 0);

    // R8: hibernate request while locked
    hibReq = 1'b1;
    cyc();
    hibReq = 1'b0;
    chk("R8 no err when locked", {31'h0, hibErr}, 32'h0);

    // R10: stray ack while idle
    autoAck = 1'b0;
    padAck = 1'b1;
    cycN(2);
    padAck = 1'b0;
    cyc();
    chk("R10 stray ack ignored", regRdata, 32'h8000_0010);
    chk("R10 no req", {31'h0, padXferReq}, 32'h0);
    autoAck = 1'b1;

    // R9: hibernate-exit reset mid-configuration
    wr(32'h0000_0011);
    cyc();
    hibExitRst = 1'b1;
    cyc();
    hibExitRst = 1'b0;
    chk("R9 read after exit reset", regRdata, 32'h8000_0000);
    chk("R9 pads cleared", {22'h0, padXferReq, padRstWakeEn, padGpioWakeEn, padGpioWakeLvl}, 32'h0);
    cycN(4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule